// File: doc/BRIEF.md
# Presettable Down Counter with Zero Detect

This block is a synchronous down counter with an active-low zero-detect output. A parameter selects one of two number systems. In binary mode the register counts through every value of its width. In BCD mode each 4-bit nibble holds one decimal digit, so the default 8-bit width counts 99 down to 00. The count decreases on each rising clock edge while the active-low count enable is asserted. When it passes zero it reloads the largest value the mode allows.

Four active-low controls act on the count, from strongest to weakest:

- a clear, which is asynchronous and forces the maximum value;
- a jam load, which is asynchronous and forces the data input into the count;
- a jam load that acts on the next clock edge;
- the count enable.

The zero-detect output is gated by the count enable. This lets several stages share one clock and be chained: one stage's zero-detect feeds the next stage's enable. Tying the zero-detect output back to the synchronous load makes the block a programmable clock divider.

The present count is brought out as a port.

Top module: `jam_down_counter`

## Requirements
- R1: While `clr_n` is low, `count` equals the maximum value (all ones in binary mode, 0x99 in BCD mode at width 8). This takes effect at once, without waiting for a clock edge, and holds whatever the other inputs are.
- R2: While `aload_n` is low and `clr_n` is high, `count` equals `jam` at once. This holds regardless of `sload_n`, `cen_n` and clock edges. The loaded value remains after `aload_n` rises, provided a clock edge occurred while `aload_n` was low.
- R3: With `clr_n` and `aload_n` high and `sload_n` low, a rising clock edge loads `jam`, even when `cen_n` is high.
- R4: With `clr_n`, `aload_n` and `sload_n` high and `cen_n` low, each rising clock edge decreases the count by one.
- R5: With `cen_n` high and no load or clear active, clock edges leave the count unchanged.
- R6: A counting edge taken at a count of zero loads the maximum value. Free-running, the counter therefore repeats every 256 clocks in binary mode and every 100 clocks in BCD mode.
- R7: `zero_n` is low exactly when the count is zero and `cen_n` is low. A count of zero with `cen_n` high keeps `zero_n` high.
- R8: In BCD mode each nibble is one decimal digit, with the tens digit in bits 7:4 and the units digit in bits 3:0. A units digit of 0 counts to 9 and borrows one from the tens digit (0x10 counts to 0x09).
- R9: In BCD mode a loaded digit above 9 is kept as given. Each decrement lowers such a digit by one, so the count returns to valid BCD (0xA5 reaches 0x99 after six counts).
- R10: With `zero_n` wired to `sload_n` and `cen_n` held low, `zero_n` pulses low for one clock every N+1 clocks, where N is the value on `jam`.
- R11: Two stages on one clock, with the first stage's `zero_n` driving the second stage's `cen_n`, count together as one double-width down counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear to the maximum value, active low |
| aload_n | input | 1 | Asynchronous load of `jam`, active low |
| sload_n | input | 1 | Load of `jam` on the next clock edge, active low |
| cen_n | input | 1 | Count enable and carry-in, active low |
| jam | input | WIDTH | Load value; in BCD mode, one decimal digit per nibble |
| zero_n | output | 1 | Zero detect and carry-out, active low, gated by `cen_n` |
| count | output | WIDTH | Present count |

## Verification
The bench builds the block at width 8 in both modes. Matching vectors drive the binary and BCD instances side by side, so the same stimulus shows a binary wrap to 0xFF next to a decimal wrap to 0x99, and a plain decrement from 0x10 next to a digit borrow. Two more instances, one per mode, have their zero-detect wired to their own synchronous load; these bring the N+1 divide ratio within reach. Two binary stages chained through enable and zero-detect show the carry between stages at the 256-clock rollover.

// File: rtl/jam_down_counter.sv
module jam_down_counter #(
  parameter int WIDTH = 8,
  parameter bit BCD   = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             aload_n,
  input  logic             sload_n,
  input  logic             cen_n,
  input  logic [WIDTH-1:0] jam,
  output logic             zero_n,
  output logic [WIDTH-1:0] count
);
  localparam int DIGITS = WIDTH / 4;
  localparam logic [WIDTH-1:0] MAX = BCD ? {DIGITS{4'h9}} : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] dec;

  generate
    if (BCD) begin : g_bcd
      logic [DIGITS-1:0] borrow;
      assign borrow[0] = 1'b1;
      for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        logic [3:0] d;
        assign d = q[4*i +: 4];
        assign dec[4*i +: 4] = !borrow[i] ? d : (d == 4'd0) ? 4'd9 : d - 4'd1;
        if (i < DIGITS - 1) begin : g_b
          assign borrow[i+1] = borrow[i] && (d == 4'd0);
        end
      end
    end else begin : g_bin
      assign dec = q - ONE;
    end
  endgenerate

  always_ff @(posedge clk or negedge clr_n or negedge aload_n) begin
    if (!clr_n)        q <= MAX;
    else if (!aload_n) q <= jam;
    else if (!sload_n) q <= jam;
    else if (!cen_n)   q <= dec;
  end

  assign count  = !clr_n ? MAX : !aload_n ? jam : q;
  assign zero_n = !((count == '0) && !cen_n);
endmodule

// File: rtl/jam_down_counter_chk.sv
module jam_down_counter_chk #(
  parameter int WIDTH = 8,
  parameter bit BCD   = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             aload_n,
  input logic             sload_n,
  input logic             cen_n,
  input logic [WIDTH-1:0] jam,
  input logic             zero_n,
  input logic [WIDTH-1:0] count
);
  localparam int DIGITS = WIDTH / 4;
  localparam logic [WIDTH-1:0] MAX = BCD ? {DIGITS{4'h9}} : {WIDTH{1'b1}};

  function automatic bit bcd_ok(input logic [WIDTH-1:0] v);
    bit ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R1
  always @(posedge clk) if (!clr_n) a_r1_clear_max: assert (count == MAX);

  a_r3_sync_load: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
    !sload_n |=> count == $past(jam));

  a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
    (cen_n && sload_n) |=> $stable(count));

  a_r6_wrap_max: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
    (!zero_n && sload_n) |=> count == MAX);

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
    (!zero_n && sload_n) |=> zero_n);

  generate
    if (BCD) begin : g_bcd_chk
      a_r8_stays_bcd: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
        (bcd_ok(count) && sload_n) |=> bcd_ok(count));
    end else begin : g_bin_chk
      a_r4_bin_step: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
        (!cen_n && sload_n && count != '0) |=> count == $past(count) - 1'b1);
    end
  endgenerate
endmodule

bind jam_down_counter jam_down_counter_chk #(.WIDTH(WIDTH), .BCD(BCD)) u_chk (
  .clk(clk), .clr_n(clr_n), .aload_n(aload_n), .sload_n(sload_n),
  .cen_n(cen_n), .jam(jam), .zero_n(zero_n), .count(count)
);

// File: tb/jam_down_counter_bench.sv
module jam_down_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 18;
  // {clr_n,aload_n,sload_n,cen_n}, jam, expected binary, expected BCD, zero_n binary, zero_n BCD
  localparam logic [29:0] VEC [N_VEC] = '{
    {4'b1101, 8'h03, 8'h03, 8'h03, 2'b11},  // R3 load while inhibited
    {4'b1110, 8'h00, 8'h02, 8'h02, 2'b11},  // R4
    {4'b1110, 8'h00, 8'h01, 8'h01, 2'b11},
    {4'b1110, 8'h00, 8'h00, 8'h00, 2'b00},  // R7 zero with enable
    {4'b1110, 8'h00, 8'hFF, 8'h99, 2'b11},  // R6 wrap
    {4'b1111, 8'h00, 8'hFF, 8'h99, 2'b11},  // R5 hold
    {4'b1100, 8'h10, 8'h10, 8'h10, 2'b11},  // R3 load beats count
    {4'b1110, 8'h10, 8'h0F, 8'h09, 2'b11},  // R8 borrow
    {4'b1110, 8'h10, 8'h0E, 8'h08, 2'b11},
    {4'b1101, 8'h00, 8'h00, 8'h00, 2'b11},  // R7 zero but inhibited
    {4'b1111, 8'h00, 8'h00, 8'h00, 2'b11},  // R5
    {4'b1110, 8'h00, 8'hFF, 8'h99, 2'b11},  // R6
    {4'b1100, 8'h20, 8'h20, 8'h20, 2'b11},
    {4'b1110, 8'h20, 8'h1F, 8'h19, 2'b11},  // R8
    {4'b1101, 8'hA5, 8'hA5, 8'hA5, 2'b11},  // R9 invalid tens kept
    {4'b1110, 8'hA5, 8'hA4, 8'hA4, 2'b11},
    {4'b1100, 8'h3C, 8'h3C, 8'h3C, 2'b11},  // R9 invalid units
    {4'b1110, 8'h3C, 8'h3B, 8'h3B, 2'b11}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       clr_n = 1'b0, aload_n = 1'b1, sload_n = 1'b1, cen_n = 1'b1;
  logic [7:0] jam = 8'h00;
  logic [7:0] cnt_bin, cnt_bcd;
  logic       z_bin, z_bcd;
  logic       clr2_n = 1'b0;
  logic [7:0] dcnt_b, dcnt_d, c0_cnt, c1_cnt;
  logic       dz_b, dz_d, c0_z, c1_z;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  jam_down_counter #(.WIDTH(8), .BCD(1'b0)) u_jam_down_counter (
    .clk(clk), .clr_n(clr_n), .aload_n(aload_n), .sload_n(sload_n),
    .cen_n(cen_n), .jam(jam), .zero_n(z_bin), .count(cnt_bin));
  jam_down_counter #(.WIDTH(8), .BCD(1'b1)) u_jam_down_counter_bcd (
    .clk(clk), .clr_n(clr_n), .aload_n(aload_n), .sload_n(sload_n),
    .cen_n(cen_n), .jam(jam), .zero_n(z_bcd), .count(cnt_bcd));
  jam_down_counter #(.WIDTH(8), .BCD(1'b0)) u_div_bin (
    .clk(clk), .clr_n(clr2_n), .aload_n(1'b1), .sload_n(dz_b),
    .cen_n(1'b0), .jam(8'h04), .zero_n(dz_b), .count(dcnt_b));
  jam_down_counter #(.WIDTH(8), .BCD(1'b1)) u_div_bcd (
    .clk(clk), .clr_n(clr2_n), .aload_n(1'b1), .sload_n(dz_d),
    .cen_n(1'b0), .jam(8'h12), .zero_n(dz_d), .count(dcnt_d));
  jam_down_counter #(.WIDTH(8), .BCD(1'b0)) u_chain0 (
    .clk(clk), .clr_n(clr2_n), .aload_n(1'b1), .sload_n(1'b1),
    .cen_n(1'b0), .jam(8'h00), .zero_n(c0_z), .count(c0_cnt));
  jam_down_counter #(.WIDTH(8), .BCD(1'b0)) u_chain1 (
    .clk(clk), .clr_n(clr2_n), .aload_n(1'b1), .sload_n(1'b1),
    .cen_n(c0_z), .jam(8'h00), .zero_n(c1_z), .count(c1_cnt));

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    int lb[3];
    int ld[3];
    int nb = 0;
    int nd = 0;
    repeat (2) @(negedge clk);
    check("R1 reset binary count", cnt_bin, 8'hFF);
    check("R1 reset BCD count", cnt_bcd, 8'h99);
    check("R7 reset zero_n", {z_bin, z_bcd}, 2'b11);
    for (int i = 0; i < N_VEC; i++) begin
      {clr_n, aload_n, sload_n, cen_n} = VEC[i][29:26];
      jam = VEC[i][25:18];
      @(negedge clk);
      check($sformatf("R4/R8 vector %0d binary count", i), cnt_bin, VEC[i][17:10]);
      check($sformatf("R4/R8 vector %0d BCD count", i), cnt_bcd, VEC[i][9:2]);
      check($sformatf("R7 vector %0d zero_n", i), {z_bin, z_bcd}, VEC[i][1:0]);
    end

    // R1 and R2: asynchronous controls and their priority
    cen_n = 1'b1; sload_n = 1'b1;
    #2 jam = 8'h42; aload_n = 1'b0; clr_n = 1'b0;
    #1 check("R1 clear over preset binary", cnt_bin, 8'hFF);
    check("R1 clear over preset BCD", cnt_bcd, 8'h99);
    clr_n = 1'b1;
    #1 check("R2 immediate preset binary", cnt_bin, 8'h42);
    check("R2 immediate preset BCD", cnt_bcd, 8'h42);
    sload_n = 1'b0; cen_n = 1'b0;
    @(negedge clk);
    check("R2 preset holds over clock", {cnt_bin, cnt_bcd}, 16'h4242);
    aload_n = 1'b1; sload_n = 1'b1;
    #1 check("R2 value kept after release", {cnt_bin, cnt_bcd}, 16'h4242);
    @(negedge clk);
    check("R4 count after preset", {cnt_bin, cnt_bcd}, 16'h4141);

    // R9: invalid BCD tens digit recovers
    sload_n = 1'b0; jam = 8'hA5;
    @(negedge clk);
    sload_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 BCD recovered", cnt_bcd, 8'h99);
    check("R9 binary reference", cnt_bin, 8'h9F);

    // R10 divider and R11 chaining
    clr2_n = 1'b1;
    for (int k = 1; k <= 320; k++) begin
      @(negedge clk);
      if (!dz_b && nb < 3) begin lb[nb] = k; nb++; end
      if (!dz_d && nd < 3) begin ld[nd] = k; nd++; end
      if (k == 256) check("R11 chain after 256", {c1_cnt, c0_cnt}, 16'hFEFF);
      if (k == 300) check("R11 chain after 300", {c1_cnt, c0_cnt}, 16'hFED3);
    end
    check("R10 binary pulses seen", nb, 3);
    check("R10 BCD pulses seen", nd, 3);
    check("R6 binary first zero", lb[0], 255);
    check("R6 BCD first zero", ld[0], 99);
    check("R10 binary period", lb[2] - lb[1], 5);
    check("R10 binary period first", lb[1] - lb[0], 5);
    check("R10 BCD period", ld[2] - ld[1], 13);
    check("R10 BCD period first", ld[1] - ld[0], 13);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule